// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment register and a 16-bit offset into a 20-bit physical memory address. It holds four segment values: code, data, stack and extra. For data accesses, the offset is an effective address built from a base value, an index value and a displacement, combined as the mode select asks. For the other kinds of access the offset comes straight from the instruction pointer, the stack pointer or the destination index.

The segment is chosen from the access type. For data accesses it also depends on whether the base register is the base pointer, and an explicit override can replace that choice. The address logic is combinational. A parameter can put one register stage on the outputs.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals the selected segment value shifted left by four with zero fill, plus the zero-extended 16-bit offset, taken modulo 2^20. For example, segment 123Ah with offset 341Bh gives 157BBh, and segment FFFFh with offset FFFFh wraps to 0FFEFh.
- R2: When `acc_type` = 0 (instruction fetch), the segment is code and the offset is `ip`. `ovr_en` has no effect.
- R3: When `acc_type` = 2 (stack), the segment is stack and the offset is `sp`. `ovr_en` has no effect.
- R4: When `acc_type` = 3 (string destination), the segment is extra and the offset is `idx_val`, which carries DI. `ovr_en` has no effect.
- R5: When `acc_type` = 1 (data) and no override is given, the segment is stack if the mode uses the base and `base_is_bp` = 1. Otherwise it is data.
- R6: When `acc_type` = 1 and `ovr_en` = 1, the segment is the one coded on `ovr_seg`, regardless of the default.
- R7: For data accesses the effective address follows `ea_mode`: 0 displacement only, 1 base only, 2 index only, 3 base+displacement, 4 index+displacement, 5 base+index, 6 and 7 base+index+displacement. Example: data segment 0210h, base FB04h and displacement 001Ah in mode 3 give 11C1Eh.
- R8: The effective-address sum wraps modulo 2^16 before the segment is added. For example, base FFFFh plus index 0002h gives 0001h.
- R9: With `REG_OUT` = 1, each output shows the result of the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are zero.
- R10: `seg_id` reports the segment used, coded as 0 extra, 1 code, 2 stack, 3 data. `ovr_seg` uses the same code. `eff_addr` reports the offset used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_mode | input | 3 | Effective-address form |
| base_is_bp | input | 1 | 1 when the base value is BP, 0 when it is BX |
| base_val | input | 16 | Base register value |
| idx_val | input | 16 | Index register value (SI or DI) |
| disp | input | 16 | Displacement |
| ip | input | 16 | Instruction pointer |
| sp | input | 16 | Stack pointer |
| acc_type | input | 2 | 0 fetch, 1 data, 2 stack, 3 string destination |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| seg_cs | input | 16 | Code segment |
| seg_ds | input | 16 | Data segment |
| seg_ss | input | 16 | Stack segment |
| seg_es | input | 16 | Extra segment |
| phys_addr | output | 20 | Physical address |
| eff_addr | output | 16 | Offset used |
| seg_id | output | 2 | Segment used |

## Verification
The bench uses random values for all four segments and all offset sources, so that a wrong segment or offset choice gives a different address. Directed cases cover the following:
- The base-pointer default, tried with modes that use the base and with modes that use only the index, which separates "BP present" from "BP selected but unused".
- An override applied to every access type, which shows that only data accesses take it.
- Sums near FFFFh, which expose a missing 16-bit or 20-bit wrap.
- A check just before the clock edge, which confirms the register latency.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int  SEG_W   = 16,
  parameter bit  REG_OUT = 1'b1,
  localparam int PA_W    = SEG_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ea_mode,
  input  logic             base_is_bp,
  input  logic [SEG_W-1:0] base_val,
  input  logic [SEG_W-1:0] idx_val,
  input  logic [SEG_W-1:0] disp,
  input  logic [SEG_W-1:0] ip,
  input  logic [SEG_W-1:0] sp,
  input  logic [1:0]       acc_type,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ds,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_es,
  output logic [PA_W-1:0]  phys_addr,
  output logic [SEG_W-1:0] eff_addr,
  output logic [1:0]       seg_id
);
  localparam logic [1:0] S_ES = 2'd0, S_CS = 2'd1, S_SS = 2'd2, S_DS = 2'd3;
  localparam logic [1:0] A_FETCH = 2'd0, A_DATA = 2'd1, A_STACK = 2'd2, A_SDST = 2'd3;

  logic use_b, use_i, use_d;
  assign use_b = ea_mode inside {3'd1, 3'd3, 3'd5, 3'd6, 3'd7};
  assign use_i = ea_mode inside {3'd2, 3'd4, 3'd5, 3'd6, 3'd7};
  assign use_d = ea_mode inside {3'd0, 3'd3, 3'd4, 3'd6, 3'd7};

  logic [SEG_W-1:0] ea_sum;
  assign ea_sum = (use_b ? base_val : '0) + (use_i ? idx_val : '0) + (use_d ? disp : '0);

  logic [SEG_W-1:0] off_c;
  logic [1:0]       sid_c;
  always_comb begin
    unique case (acc_type)
      A_FETCH: begin off_c = ip;      sid_c = S_CS; end
      A_STACK: begin off_c = sp;      sid_c = S_SS; end
      A_SDST:  begin off_c = idx_val; sid_c = S_ES; end
      default: begin
        off_c = ea_sum;
        if (ovr_en)                  sid_c = ovr_seg;
        else if (use_b && base_is_bp) sid_c = S_SS;
        else                         sid_c = S_DS;
      end
    endcase
  end

  logic [SEG_W-1:0] segv;
  always_comb begin
    unique case (sid_c)
      S_ES:    segv = seg_es;
      S_CS:    segv = seg_cs;
      S_SS:    segv = seg_ss;
      default: segv = seg_ds;
    endcase
  end

  logic [PA_W-1:0] pa_c;
  assign pa_c = {segv, 4'b0000} + {4'b0000, off_c};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phys_addr <= '0;
        eff_addr  <= '0;
        seg_id    <= '0;
      end else begin
        phys_addr <= pa_c;
        eff_addr  <= off_c;
        seg_id    <= sid_c;
      end
    end
  end else begin : g_comb
    assign phys_addr = pa_c;
    assign eff_addr  = off_c;
    assign seg_id    = sid_c;
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int  SEG_W   = 16,
  parameter bit  REG_OUT = 1'b1,
  localparam int PA_W    = SEG_W + 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       ea_mode,
  input logic             base_is_bp,
  input logic [SEG_W-1:0] base_val,
  input logic [SEG_W-1:0] idx_val,
  input logic [SEG_W-1:0] disp,
  input logic [SEG_W-1:0] ip,
  input logic [SEG_W-1:0] sp,
  input logic [1:0]       acc_type,
  input logic             ovr_en,
  input logic [1:0]       ovr_seg,
  input logic [SEG_W-1:0] seg_cs,
  input logic [SEG_W-1:0] seg_ds,
  input logic [SEG_W-1:0] seg_ss,
  input logic [SEG_W-1:0] seg_es,
  input logic [PA_W-1:0]  phys_addr,
  input logic [SEG_W-1:0] eff_addr,
  input logic [1:0]       seg_id
);
  logic             q_ok, q_bp, q_ovr;
  logic [2:0]       q_mode;
  logic [1:0]       q_acc, q_oseg;
  logic [SEG_W-1:0] q_ip, q_sp, q_idx, q_cs, q_ds, q_ss, q_es;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ok <= 1'b0; q_bp <= 1'b0; q_ovr <= 1'b0; q_mode <= '0; q_acc <= '0; q_oseg <= '0;
      q_ip <= '0; q_sp <= '0; q_idx <= '0; q_cs <= '0; q_ds <= '0; q_ss <= '0; q_es <= '0;
    end else begin
      q_ok <= 1'b1; q_bp <= base_is_bp; q_ovr <= ovr_en; q_mode <= ea_mode; q_acc <= acc_type;
      q_oseg <= ovr_seg; q_ip <= ip; q_sp <= sp; q_idx <= idx_val;
      q_cs <= seg_cs; q_ds <= seg_ds; q_ss <= seg_ss; q_es <= seg_es;
    end
  end

  logic             v_ok, v_bp, v_ovr;
  logic [2:0]       v_mode;
  logic [1:0]       v_acc, v_oseg;
  logic [SEG_W-1:0] v_ip, v_sp, v_idx, v_seg;
  assign v_ok   = REG_OUT ? q_ok   : 1'b1;
  assign v_bp   = REG_OUT ? q_bp   : base_is_bp;
  assign v_ovr  = REG_OUT ? q_ovr  : ovr_en;
  assign v_mode = REG_OUT ? q_mode : ea_mode;
  assign v_acc  = REG_OUT ? q_acc  : acc_type;
  assign v_oseg = REG_OUT ? q_oseg : ovr_seg;
  assign v_ip   = REG_OUT ? q_ip   : ip;
  assign v_sp   = REG_OUT ? q_sp   : sp;
  assign v_idx  = REG_OUT ? q_idx  : idx_val;
  assign v_seg  = (seg_id == 2'd0) ? (REG_OUT ? q_es : seg_es) :
                  (seg_id == 2'd1) ? (REG_OUT ? q_cs : seg_cs) :
                  (seg_id == 2'd2) ? (REG_OUT ? q_ss : seg_ss) :
                                     (REG_OUT ? q_ds : seg_ds);

  p_phys_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_ok |-> phys_addr == PA_W'({v_seg, 4'b0000} + {4'b0000, eff_addr}));
  p_fetch_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ok && v_acc == 2'd0) |-> (seg_id == 2'd1 && eff_addr == v_ip));
  p_stack_ss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ok && v_acc == 2'd2) |-> (seg_id == 2'd2 && eff_addr == v_sp));
  p_strdst_es_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ok && v_acc == 2'd3) |-> (seg_id == 2'd0 && eff_addr == v_idx));
  p_bp_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ok && v_acc == 2'd1 && !v_ovr && v_bp && v_mode inside {3'd1, 3'd3, 3'd5, 3'd6, 3'd7})
      |-> seg_id == 2'd2);
  p_ds_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ok && v_acc == 2'd1 && !v_ovr && !v_bp) |-> seg_id == 2'd3);
  p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ok && v_acc == 2'd1 && v_ovr) |-> seg_id == v_oseg);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ea_mode = '0;
  logic        base_is_bp = 1'b0;
  logic [15:0] base_val = '0, idx_val = '0, disp = '0, ip = '0, sp = '0;
  logic [1:0]  acc_type = '0, ovr_seg = '0;
  logic        ovr_en = 1'b0;
  logic [15:0] seg_cs = '0, seg_ds = '0, seg_ss = '0, seg_es = '0;
  logic [19:0] phys_addr;
  logic [15:0] eff_addr;
  logic [1:0]  seg_id;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_addr_gen #(.SEG_W(16), .REG_OUT(1'b1)) dut_i (.*);

  function automatic logic [15:0] f_ea();
    logic [15:0] s = '0;
    if (ea_mode inside {1, 3, 5, 6, 7}) s += base_val;
    if (ea_mode inside {2, 4, 5, 6, 7}) s += idx_val;
    if (ea_mode inside {0, 3, 4, 6, 7}) s += disp;
    return s;
  endfunction

  function automatic logic [1:0] f_seg();
    case (acc_type)
      2'd0: return 2'd1;
      2'd2: return 2'd2;
      2'd3: return 2'd0;
      default: begin
        if (ovr_en) return ovr_seg;
        if (base_is_bp && ea_mode inside {1, 3, 5, 6, 7}) return 2'd2;
        return 2'd3;
      end
    endcase
  endfunction

  function automatic logic [15:0] f_off();
    case (acc_type)
      2'd0: return ip;
      2'd2: return sp;
      2'd3: return idx_val;
      default: return f_ea();
    endcase
  endfunction

  function automatic logic [19:0] f_pa();
    logic [15:0] s;
    case (f_seg())
      2'd0: s = seg_es;
      2'd1: s = seg_cs;
      2'd2: s = seg_ss;
      default: s = seg_ds;
    endcase
    return {s, 4'h0} + {4'h0, f_off()};
  endfunction

  task automatic chk(string req, logic [19:0] epa, logic [15:0] eea, logic [1:0] esg);
    n_chk++;
    if (phys_addr !== epa || eff_addr !== eea || seg_id !== esg) begin
      n_bad++;
      $display("FAIL %s: got pa=%h ea=%h seg=%0d, expected pa=%h ea=%h seg=%0d",
               req, phys_addr, eff_addr, seg_id, epa, eea, esg);
    end
  endtask

  // Inputs are driven at the falling edge; the registered result is sampled just after the next rising edge.
  task automatic run(string req);
    logic [19:0] pa; logic [15:0] ea; logic [1:0] sg;
    pa = f_pa(); ea = f_off(); sg = f_seg();
    @(posedge clk); #1;
    chk(req, pa, ea, sg);
    @(negedge clk);
  endtask

  task automatic set_data(logic [2:0] m, logic bp, logic [15:0] b, logic [15:0] x, logic [15:0] d);
    acc_type = 2'd1; ea_mode = m; base_is_bp = bp; base_val = b; idx_val = x; disp = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd4711);
    seg_cs = 16'h1111; ip = 16'h2222;
    repeat (3) @(posedge clk);
    #1 chk("R9 reset", 20'h0, 16'h0, 2'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R2: fetch, override must be ignored
    seg_cs = 16'h123A; ip = 16'h341B; acc_type = 2'd0; ovr_en = 1'b1; ovr_seg = 2'd3;
    run("R1 R2 fetch 157BB");
    chk("R2 fetch pa", 20'h157BB, 16'h341B, 2'd1);
    // R1 wrap
    seg_cs = 16'hFFFF; ip = 16'hFFFF; ovr_en = 1'b0;
    run("R1 20-bit wrap");
    chk("R1 wrap value", 20'h0FFEF, 16'hFFFF, 2'd1);
    // R7 example
    seg_ds = 16'h0210; set_data(3'd3, 1'b0, 16'hFB04, 16'h0, 16'h001A);
    run("R7 base+disp");
    chk("R7 11C1E", 20'h11C1E, 16'hFB1E, 2'd3);
    // R8 EA wrap
    set_data(3'd5, 1'b0, 16'hFFFF, 16'h0002, 16'h0);
    run("R8 ea wrap");
    chk("R8 ea 0001", 20'h02101, 16'h0001, 2'd3);
    // R5: BP with base used -> SS; BP with index-only -> DS
    seg_ss = 16'h8050; set_data(3'd1, 1'b1, 16'h1800, 16'h7777, 16'h5);
    run("R5 bp base");
    chk("R5 bp to SS", 20'h81D00, 16'h1800, 2'd2);
    set_data(3'd2, 1'b1, 16'h1800, 16'h0040, 16'h5);
    run("R5 bp unused stays DS");
    // R6 override on data, each code (R10)
    for (int s = 0; s < 4; s++) begin
      seg_es = 16'hE000; set_data(3'd6, 1'b1, 16'h10, 16'h20, 16'h30);
      ovr_en = 1'b1; ovr_seg = 2'(s);
      run("R6 R10 override data");
    end
    // R3, R4: override ignored
    acc_type = 2'd2; sp = 16'hFFFE; ovr_seg = 2'd0;
    run("R3 stack ignores override");
    acc_type = 2'd3; idx_val = 16'h0100; ovr_seg = 2'd3;
    run("R4 string dest ignores override");
    ovr_en = 1'b0;

    // R9: output still holds old result just before the edge
    begin
      logic [19:0] opa; logic [15:0] oea; logic [1:0] osg;
      opa = f_pa(); oea = f_off(); osg = f_seg();
      @(posedge clk); #1;
      acc_type = 2'd0; ip = 16'h0ABC; seg_cs = 16'h0001;
      @(negedge clk); #1;
      chk("R9 latency hold", opa, oea, osg);
      @(posedge clk); #1;
      chk("R9 latency update", 20'h00ACC, 16'h0ABC, 2'd1);
      @(negedge clk);
    end

    for (int i = 0; i < 400; i++) begin
      ea_mode = 3'($urandom); base_is_bp = 1'($urandom); base_val = 16'($urandom);
      idx_val = 16'($urandom); disp = 16'($urandom); ip = 16'($urandom); sp = 16'($urandom);
      acc_type = 2'($urandom); ovr_en = 1'($urandom); ovr_seg = 2'($urandom);
      seg_cs = 16'($urandom); seg_ds = 16'($urandom); seg_ss = 16'($urandom); seg_es = 16'($urandom);
      run("R1 R2 R3 R4 R5 R6 R7 R8 R10 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule